// File: doc/BRIEF.md
# Dual-Channel Serial Converter Code Loader

This block is the digital front end of a two-channel 12-bit digital-to-analog converter. A host shifts a 24-bit frame over a three-wire serial link: a serial clock, a data line and an active-low frame select. The bits land in one shared shift chain. Two active-low commit strobes then copy fixed halves of that chain into two output holding registers, one for channel A and one for channel B. Each strobe can fire alone, or both can fire in the same transfer. The two holding registers drive the converter codes.

The serial pins are not a clock domain of their own. A system clock at least four times the serial clock oversamples them. Every serial input passes through a two-flop synchronizer, and edge detection on the synchronized copies produces single-cycle shift and commit pulses. An active-low zero input clears the chain and both codes asynchronously. A synchronous active-low system reset does the same and also returns the synchronizers to their idle levels.

Within each half the bit order is reversed. A frame therefore carries the channel B code first and the channel A code second, each most significant bit first.

Top module: `dual_serial_dac_loader`

## Requirements
- R1: Each active serial clock edge (the falling edge by default), seen while frame select is low, enters the data bit at chain position 23 and moves every earlier bit one position toward position 0. The bit that was at position 12 goes to position 11.
- R2: While the synchronized frame select is high, serial clock edges do not change the chain and commit strobes do not change either code.
- R3: A falling edge on commit A with frame select low loads chain positions 12 to 23 into the channel A code. Position 12 becomes bit 11 (MSB) and position 23 becomes bit 0 (LSB).
- R4: A falling edge on commit B with frame select low loads chain positions 0 to 11 into the channel B code. Position 0 becomes bit 11 (MSB) and position 11 becomes bit 0 (LSB).
- R5: Commit strobes that fall together load both codes in the same transfer. A single strobe leaves the other channel's code unchanged.
- R6: Zero low clears the chain and both codes at once, without waiting for a clock edge, and overrides every other input for as long as it is held.
- R7: After 24 bits, the first 12 bits shifted in form the channel B code and the last 12 form the channel A code, each sent MSB first.
- R8: A commit strobe that is held low loads only once. Later shifting does not reach that code until the strobe rises and falls again.
- R9: With the default two synchronizer stages, a new code appears after the third rising system clock edge that samples the commit strobe low. It is still unchanged after the first and second such edges.
- R10: System reset low at a rising clock edge clears the chain and both codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock, at least 4x the serial clock |
| sys_rst_n | input | 1 | Synchronous active-low reset |
| zero_n | input | 1 | Asynchronous active-low clear of chain and codes |
| ser_clk | input | 1 | Serial bit clock (asynchronous) |
| ser_din | input | 1 | Serial data, MSB first |
| frame_sel_n | input | 1 | Active-low frame select |
| commit_a_n | input | 1 | Active-low load strobe for channel A |
| commit_b_n | input | 1 | Active-low load strobe for channel B |
| chan_a_code | output | HALF_W | Channel A converter code |
| chan_b_code | output | HALF_W | Channel B converter code |

## Verification
The bench builds the block with its defaults: 12-bit halves, two synchronizer stages and a falling active serial edge. The 12-bit halves allow all-zero and all-ones codes as boundary cases. They also allow asymmetric codes such as 0xA5C and 0x3C5, which expose any slip in bit reversal or half assignment. Two synchronizer stages fix the commit latency at exactly three edges, so the reference model can be compared on every clock and the latency can be pinned down edge by edge.

// File: rtl/dsl_pkg.sv
// Shared types for the dual-channel serial loader.
// Assumes: all serial-side pins are grouped into one packed vector so that a
// single synchronizer instance can carry them with a common latency.
package dsl_pkg;

    // Serial-side pins as one packed group, MSB first.
    typedef struct packed {
        logic ser_clk;
        logic ser_din;
        logic sel_n;
        logic commit_a_n;
        logic commit_b_n;
    } ser_pins_t;

    localparam int PINS_W = $bits(ser_pins_t);

    // Channel indices inside the generate loop over holding registers.
    localparam int CH_B = 0;
    localparam int CH_A = 1;
    localparam int NUM_CH = 2;

endpackage

// File: rtl/dsl_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs, plus one
// extra delayed copy for edge detection.
// Assumes: each bit is independent (no bus coherency needed); the sender
// holds each level for several system clocks.
module dsl_sync #(
    parameter int              W       = 5,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);

    localparam int DEPTH = STAGES + 1;

    logic [W-1:0] stage [DEPTH];

    // Shift the sampled inputs down the flop chain; reset to idle levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) begin
                stage[s] <= RST_VAL;
            end
        end else begin
            stage[0] <= d;
            for (int s = 1; s < DEPTH; s++) begin
                stage[s] <= stage[s-1];
            end
        end
    end

    assign q      = stage[STAGES-1];
    assign q_prev = stage[STAGES];

endmodule

// File: rtl/dsl_shift_chain.sv
// Shared serial shift chain. A new bit enters at the top position and the
// older bits move toward position 0.
// Assumes: shift_en is a single-cycle pulse already qualified by frame select.
module dsl_shift_chain #(
    parameter int DEPTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zero_n,
    input  logic             shift_en,
    input  logic             din,
    output logic [DEPTH-1:0] chain
);

    // Asynchronous clear, then synchronous reset, then shift on enable.
    always_ff @(posedge clk or negedge zero_n) begin
        if (!zero_n) begin
            chain <= '0;
        end else if (!rst_n) begin
            chain <= '0;
        end else if (shift_en) begin
            chain <= {din, chain[DEPTH-1:1]};
        end
    end

    // R1: the bit presented with a shift pulse appears at the top position.
    p_entry_at_top_r1: assert property (@(posedge clk) disable iff (!rst_n || !zero_n)
        shift_en |=> chain[DEPTH-1] == $past(din));

    // R1: the earlier top bit moves down by one position.
    p_moves_down_r1: assert property (@(posedge clk) disable iff (!rst_n || !zero_n)
        shift_en |=> chain[DEPTH-2] == $past(chain[DEPTH-1]));

    // R2: without a qualified edge the chain holds its content.
    p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n || !zero_n)
        !shift_en |=> $stable(chain));

endmodule

// File: rtl/dsl_hold_reg.sv
// Output holding register for one channel. It loads a chain half with the
// bit order reversed: the lowest chain position becomes the code MSB.
// Assumes: load is a single-cycle pulse already qualified by frame select.
module dsl_hold_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         zero_n,
    input  logic         load,
    input  logic [W-1:0] half,
    output logic [W-1:0] code
);

    logic [W-1:0] half_rev;

    // Reverse the half so the lowest position lands in the MSB.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            half_rev[W-1-i] = half[i];
        end
    end

    // Asynchronous clear, then synchronous reset, then load on pulse.
    always_ff @(posedge clk or negedge zero_n) begin
        if (!zero_n) begin
            code <= '0;
        end else if (!rst_n) begin
            code <= '0;
        end else if (load) begin
            code <= half_rev;
        end
    end

    // R2/R5: without a load pulse the code holds its value.
    p_no_load_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n || !zero_n)
        !load |=> $stable(code));

endmodule

// File: rtl/dual_serial_dac_loader.sv
// Top level of the dual-channel serial loader. It oversamples the serial
// pins on the system clock, detects the active serial edge and the commit
// strobe falls, and drives one shared shift chain and two holding registers.
// Assumes: the system clock runs at least 4x the serial clock, and every
// serial pin holds each level for at least two system clocks.
module dual_serial_dac_loader
    import dsl_pkg::*;
#(
    parameter int HALF_W           = 12,
    parameter int SYNC_STAGES      = 2,
    parameter bit SCLK_FALL_ACTIVE = 1'b1
) (
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    input  logic              zero_n,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              frame_sel_n,
    input  logic              commit_a_n,
    input  logic              commit_b_n,
    output logic [HALF_W-1:0] chan_a_code,
    output logic [HALF_W-1:0] chan_b_code
);

    localparam int        CHAIN_W  = NUM_CH * HALF_W;
    localparam ser_pins_t PINS_IDLE = '{
        ser_clk:    SCLK_FALL_ACTIVE,
        ser_din:    1'b0,
        sel_n:      1'b1,
        commit_a_n: 1'b1,
        commit_b_n: 1'b1
    };

    ser_pins_t             pins_raw;
    ser_pins_t             pins_now;
    ser_pins_t             pins_old;
    logic [PINS_W-1:0]     sync_q;
    logic [PINS_W-1:0]     sync_q_prev;
    logic                  ser_edge;
    logic                  shift_en;
    logic [NUM_CH-1:0]     commit;
    logic [CHAIN_W-1:0]    chain;
    logic [HALF_W-1:0]     codes [NUM_CH];

    // Group the asynchronous serial pins for a single synchronizer.
    always_comb begin
        pins_raw.ser_clk    = ser_clk;
        pins_raw.ser_din    = ser_din;
        pins_raw.sel_n      = frame_sel_n;
        pins_raw.commit_a_n = commit_a_n;
        pins_raw.commit_b_n = commit_b_n;
    end

    dsl_sync #(
        .W       (PINS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk    (sys_clk),
        .rst_n  (sys_rst_n),
        .d      (pins_raw),
        .q      (sync_q),
        .q_prev (sync_q_prev)
    );

    assign pins_now = ser_pins_t'(sync_q);
    assign pins_old = ser_pins_t'(sync_q_prev);

    // Pick the active serial clock polarity.
    generate
        if (SCLK_FALL_ACTIVE) begin : g_fall_edge
            assign ser_edge = pins_old.ser_clk & ~pins_now.ser_clk;
        end else begin : g_rise_edge
            assign ser_edge = ~pins_old.ser_clk & pins_now.ser_clk;
        end
    endgenerate

    // Qualify shift and commit pulses with the synchronized frame select.
    always_comb begin
        shift_en       = ser_edge & ~pins_now.sel_n;
        commit[CH_A]   = pins_old.commit_a_n & ~pins_now.commit_a_n & ~pins_now.sel_n;
        commit[CH_B]   = pins_old.commit_b_n & ~pins_now.commit_b_n & ~pins_now.sel_n;
    end

    dsl_shift_chain #(
        .DEPTH (CHAIN_W)
    ) u_chain (
        .clk      (sys_clk),
        .rst_n    (sys_rst_n),
        .zero_n   (zero_n),
        .shift_en (shift_en),
        .din      (pins_now.ser_din),
        .chain    (chain)
    );

    // One holding register per channel, each on its own half of the chain.
    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_hold
            dsl_hold_reg #(
                .W (HALF_W)
            ) u_hold (
                .clk    (sys_clk),
                .rst_n  (sys_rst_n),
                .zero_n (zero_n),
                .load   (commit[ch]),
                .half   (chain[ch*HALF_W +: HALF_W]),
                .code   (codes[ch])
            );
        end
    endgenerate

    assign chan_a_code = codes[CH_A];
    assign chan_b_code = codes[CH_B];

    // R3: channel A takes position 12 as MSB and the top position as LSB.
    p_a_bit_order_r3: assert property (@(posedge sys_clk) disable iff (!sys_rst_n || !zero_n)
        commit[CH_A] |=> (chan_a_code[HALF_W-1] == $past(chain[HALF_W]))
                      && (chan_a_code[0] == $past(chain[CHAIN_W-1])));

    // R4: channel B takes position 0 as MSB and position 11 as LSB.
    p_b_bit_order_r4: assert property (@(posedge sys_clk) disable iff (!sys_rst_n || !zero_n)
        commit[CH_B] |=> (chan_b_code[HALF_W-1] == $past(chain[0]))
                      && (chan_b_code[0] == $past(chain[HALF_W-1])));

    // R8: a commit pulse never repeats on the next cycle.
    p_single_commit_r8: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        commit[CH_A] |=> !commit[CH_A]);

    // R6: while zero is held, chain and codes stay cleared.
    p_zero_override_r6: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        !zero_n |-> (chain == '0) && (chan_a_code == '0) && (chan_b_code == '0));

    // R2: no commit while the synchronized frame select is high.
    p_sel_blocks_commit_r2: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        pins_now.sel_n |-> commit == '0);

endmodule

// File: tb/dual_serial_dac_loader_bench.sv
`timescale 1ns/1ps
module dual_serial_dac_loader_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        zero_n = 1'b1;
    logic        ser_clk = 1'b1;
    logic        ser_din = 1'b0;
    logic        sel_n = 1'b1;
    logic        cmt_a_n = 1'b1;
    logic        cmt_b_n = 1'b1;
    logic [11:0] code_a;
    logic [11:0] code_b;

    int    vectors = 0;
    int    miscompares = 0;
    bit    armed = 1'b0;
    bit    done = 1'b0;
    string phase = "R10";

    // Reference model state: chain as a bit queue (index = position).
    bit mdl[$];
    int ma = 0;
    int mb = 0;
    int h1[5];
    int h2[5];
    int h3[5];
    int cur[5];
    int idle_v[5] = '{1, 0, 1, 1, 1};
    bit fa, fb, sh;

    always #2.5 clk = ~clk;

    dual_serial_dac_loader u_dual_serial_dac_loader (
        .sys_clk     (clk),
        .sys_rst_n   (rst_n),
        .zero_n      (zero_n),
        .ser_clk     (ser_clk),
        .ser_din     (ser_din),
        .frame_sel_n (sel_n),
        .commit_a_n  (cmt_a_n),
        .commit_b_n  (cmt_b_n),
        .chan_a_code (code_a),
        .chan_b_code (code_b)
    );

    function automatic int pack_half(int base);
        int v = 0;
        for (int i = 0; i < 12; i++) v = v * 2 + int'(mdl[base + i]);
        return v;
    endfunction

    task automatic model_zero();
        mdl = {};
        repeat (24) mdl.push_back(1'b0);
        ma = 0;
        mb = 0;
    endtask

    initial begin
        model_zero();
        h1 = idle_v; h2 = idle_v; h3 = idle_v;
    end

    // Behavioural model: inputs seen two edges late, edges from history.
    always @(posedge clk) begin
        cur = '{int'(ser_clk), int'(ser_din), int'(sel_n), int'(cmt_a_n), int'(cmt_b_n)};
        if (!rst_n) begin
            h1 = idle_v; h2 = idle_v; h3 = idle_v;
            model_zero();
        end else begin
            if (!zero_n) begin
                model_zero();
            end else begin
                fa = (h3[3] == 1) && (h2[3] == 0) && (h2[2] == 0);
                fb = (h3[4] == 1) && (h2[4] == 0) && (h2[2] == 0);
                sh = (h3[0] == 1) && (h2[0] == 0) && (h2[2] == 0);
                if (fa) ma = pack_half(12);
                if (fb) mb = pack_half(0);
                if (sh) begin
                    mdl.push_back(h2[1] != 0);
                    void'(mdl.pop_front());
                end
            end
            h3 = h2; h2 = h1; h1 = cur;
        end
    end

    // Every-clock comparison against the model.
    always @(negedge clk) begin
        if (armed && !done) begin
            vectors++;
            if (code_a !== ma[11:0] || code_b !== mb[11:0]) begin
                miscompares++;
                $display("FAIL %s cycle model: a=%h b=%h expected a=%h b=%h",
                         phase, code_a, code_b, ma[11:0], mb[11:0]);
            end
        end
    end

    task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic send_bit(bit b);
        ser_din = b;
        step(3);
        ser_clk = 1'b0;
        step(3);
        ser_clk = 1'b1;
        step(3);
    endtask

    task automatic send_word(logic [11:0] v);
        for (int i = 11; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_frame(logic [11:0] b, logic [11:0] a);
        sel_n = 1'b0;
        step(3);
        send_word(b);
        send_word(a);
    endtask

    task automatic strobe(bit a, bit b);
        if (a) cmt_a_n = 1'b0;
        if (b) cmt_b_n = 1'b0;
        step(4);
        cmt_a_n = 1'b1;
        cmt_b_n = 1'b1;
        step(4);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        armed = 1'b1;
        phase = "R10";
        chk("R10 reset code_a", code_a, 12'h000);
        chk("R10 reset code_b", code_b, 12'h000);

        // R3 R5 R7: frame B=3C5 then A=A5C, commit A alone.
        phase = "R3";
        send_frame(12'h3C5, 12'hA5C);
        strobe(1'b1, 1'b0);
        chk("R3 channel A load", code_a, 12'hA5C);
        chk("R5 channel B untouched", code_b, 12'h000);
        phase = "R4";
        strobe(1'b0, 1'b1);
        chk("R4 channel B load", code_b, 12'h3C5);
        chk("R7 frame order A half", code_a, 12'hA5C);

        // R2: select high, clocks and strobes ignored, chain untouched.
        phase = "R2";
        sel_n = 1'b1;
        step(3);
        send_word(12'hFFF);
        send_word(12'h0F0);
        strobe(1'b1, 1'b1);
        chk("R2 code_a held", code_a, 12'hA5C);
        chk("R2 code_b held", code_b, 12'h3C5);
        sel_n = 1'b0;
        step(3);
        strobe(1'b1, 1'b1);
        chk("R2 chain unchanged A", code_a, 12'hA5C);
        chk("R2 chain unchanged B", code_b, 12'h3C5);

        // R1: 12 more bits move the A half into the B half.
        phase = "R1";
        send_word(12'h123);
        strobe(1'b0, 1'b1);
        chk("R1 old A half now in B", code_b, 12'hA5C);
        strobe(1'b1, 1'b0);
        chk("R1 new bits in A", code_a, 12'h123);

        // R5: both strobes together, boundary codes.
        phase = "R5";
        send_frame(12'hFFF, 12'h000);
        strobe(1'b1, 1'b1);
        chk("R5 joint load A", code_a, 12'h000);
        chk("R5 joint load B", code_b, 12'hFFF);

        // R9: latency of a commit, edge by edge.
        phase = "R9";
        send_frame(12'h800, 12'h001);
        cmt_a_n = 1'b0;
        step(1);
        chk("R9 after edge 1", code_a, 12'h000);
        step(1);
        chk("R9 after edge 2", code_a, 12'h000);
        step(1);
        chk("R9 after edge 3", code_a, 12'h001);
        step(3);
        cmt_a_n = 1'b1;
        step(4);
        strobe(1'b0, 1'b1);
        chk("R9 channel B", code_b, 12'h800);

        // R8: held strobe loads once only.
        phase = "R8";
        cmt_a_n = 1'b0;
        step(4);
        send_frame(12'h555, 12'hAAA);
        chk("R8 held strobe no reload", code_a, 12'h001);
        cmt_a_n = 1'b1;
        step(4);
        strobe(1'b1, 1'b0);
        chk("R8 fresh strobe loads", code_a, 12'hAAA);

        // R6: asynchronous zero overrides everything.
        phase = "R6";
        zero_n = 1'b0;
        #1;
        chk("R6 immediate clear A", code_a, 12'h000);
        chk("R6 immediate clear B", code_b, 12'h000);
        step(2);
        send_word(12'hFFF);
        strobe(1'b1, 1'b1);
        chk("R6 held clear A", code_a, 12'h000);
        zero_n = 1'b1;
        step(3);
        strobe(1'b1, 1'b1);
        chk("R6 chain cleared A", code_a, 12'h000);
        chk("R6 chain cleared B", code_b, 12'h000);

        step(4);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule